// File: doc/BRIEF.md
# Sidetone Coefficient and Gain Register File

This block is the register-mapped control front end of an audio sidetone filter. Software on a simple 32-bit register bus programs two signed channel gains, switches the sidetone path on and off, manages a clock-idle request, and fills a table of signed 16-bit filter taps. The filter datapath reads the table back through its own random-access read port and takes the gains and the enable from dedicated outputs.

The taps are not individually addressed. Software sets a coefficient-write-enable bit and then writes the same data port once per tap. Each accepted write lands in the next slot, starting at slot 0. After the last slot is filled, a read-only done flag appears in the control register and a load-complete interrupt status bit is raised. Software polls the flag and then drops the write enable. Setting the write enable again from 0 restarts the load at slot 0. The revision register returns a fixed constant. The interrupt output combines the status bit with a software enable.

Top module: `stcf_regfile`

## Requirements
- R1: After reset: system configuration reads 0x1 (auto-idle set); control, gain, interrupt status and interrupt enable read 0; every coefficient slot holds 0; st_enable is 0, clk_gate_req is 1 and irq is 0.
- R2: Offset 0x00 always reads the REVISION parameter (default 0x00000010), and writes to it have no effect. Offsets that are not mapped, including unaligned ones, read 0. The coefficient data port at 0x28 also reads 0.
- R3: The gain register at 0x24 is read/write. Bits 15:0 drive gain0 and bits 31:16 drive gain1, one cycle after the write.
- R4: While control bit 1 (write enable, register 0x2C) is 1, each write to 0x28 stores bits 15:0 into the next slot in order from slot 0. Any signed 16-bit value from -32768 to 32767 is stored unchanged and is visible on coef_rdata at coef_raddr.
- R5: Control bit 2 is a read-only done flag. It reads 1 only after exactly DEPTH (128) accepted data writes, and it stays 0 after DEPTH-1 writes.
- R6: A data write while the write enable is 0 stores nothing and does not advance the slot index. A data write after all DEPTH slots are full changes no slot and leaves the done flag at 1.
- R7: A control write that takes bit 1 from 0 to 1 resets the slot index to 0 and clears the done flag. Clearing bit 1 leaves the done flag as it was.
- R8: Control bit 0 drives st_enable. clk_gate_req is 1 only when system configuration bit 0 (auto-idle) is 1 and control bit 0 is 0.
- R9: Interrupt status bit 0 (0x18) is set in the cycle after the write that fills the last slot. Writing 1 to it clears it, and writing 0 leaves it unchanged. Interrupt enable bit 0 (0x1C) is read/write, and irq equals status bit 0 AND enable bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| coef_raddr | input | log2(DEPTH) (7) | Coefficient read index from the filter |
| coef_rdata | output | CW (16) | Coefficient at coef_raddr |
| gain0 | output | GW (16) | Channel 0 gain |
| gain1 | output | GW (16) | Channel 1 gain |
| st_enable | output | 1 | Sidetone path enable |
| clk_gate_req | output | 1 | Clock gating permitted |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- the revision read value;
- the gain outputs following a gain write;
- the done flag rising only out of an accepted data write, and holding through overrun writes;
- re-arming clearing the done flag;
- st_enable excluding the clock-gate request;
- write-1-to-clear of the interrupt.

The ordering of slots, the exact count of 128 writes to done, the ignoring of disabled writes and the contents of the whole table can only be shown by the bench's load scenarios. The bench shows them by comparing every slot and register against its behavioural model.

// File: rtl/stcf_pkg.sv
package stcf_pkg;
   localparam int DATA_W = 32;
   localparam logic [7:0] OFS_REV    = 8'h00;
   localparam logic [7:0] OFS_SYSCFG = 8'h10;
   localparam logic [7:0] OFS_ISTAT  = 8'h18;
   localparam logic [7:0] OFS_IEN    = 8'h1C;
   localparam logic [7:0] OFS_GAIN   = 8'h24;
   localparam logic [7:0] OFS_COEF   = 8'h28;
   localparam logic [7:0] OFS_CTRL   = 8'h2C;
   localparam int CTRL_EN   = 0;
   localparam int CTRL_WREN = 1;
   localparam int CTRL_DONE = 2;
   localparam int SYS_AIDLE = 0;
   localparam int IRQ_LOAD  = 0;
endpackage

// File: rtl/stcf_coef_mem.sv
module stcf_coef_mem #(
   parameter int DEPTH     = 128,
   parameter int CW        = 16,
   parameter bit MEM_RESET = 1'b1,
   localparam int IDXW     = $clog2(DEPTH),
   localparam int CNTW     = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_strobe,
   input  logic [CW-1:0]   wr_data,
   input  logic            wren,
   input  logic            arm,
   input  logic [IDXW-1:0] rd_idx,
   output logic [CW-1:0]   rd_data,
   output logic            full,
   output logic            fill_pulse
);
   logic [CNTW-1:0] cnt;
   logic [CW-1:0]   mem [DEPTH];
   logic            fire;

   assign full       = (cnt == CNTW'(DEPTH));
   assign fire       = wr_strobe & wren & ~full;
   assign fill_pulse = fire & (cnt == CNTW'(DEPTH - 1));
   assign rd_data    = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (arm)  cnt <= '0;
      else if (fire) cnt <= cnt + 1'b1;
   end

   generate
      if (MEM_RESET) begin : g_mem_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (fire) begin
               mem[cnt[IDXW-1:0]] <= wr_data;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (fire) mem[cnt[IDXW-1:0]] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/stcf_ctrl_regs.sv
module stcf_ctrl_regs
   import stcf_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int GW         = 16,
   parameter bit AIDLE_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fill_pulse,
   output logic              aidle,
   output logic              st_en,
   output logic              wren,
   output logic              arm,
   output logic              istat,
   output logic              ien,
   output logic [GW-1:0]     gain0,
   output logic [GW-1:0]     gain1
);
   logic hit_sys, hit_ist, hit_ien, hit_gain, hit_ctrl;

   assign hit_sys  = wr & (addr == ADDR_W'(OFS_SYSCFG));
   assign hit_ist  = wr & (addr == ADDR_W'(OFS_ISTAT));
   assign hit_ien  = wr & (addr == ADDR_W'(OFS_IEN));
   assign hit_gain = wr & (addr == ADDR_W'(OFS_GAIN));
   assign hit_ctrl = wr & (addr == ADDR_W'(OFS_CTRL));
   assign arm      = hit_ctrl & wdata[CTRL_WREN] & ~wren;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aidle <= AIDLE_RST;
         st_en <= 1'b0;
         wren  <= 1'b0;
         ien   <= 1'b0;
         gain0 <= '0;
         gain1 <= '0;
      end else begin
         if (hit_sys) aidle <= wdata[SYS_AIDLE];
         if (hit_ien) ien   <= wdata[IRQ_LOAD];
         if (hit_ctrl) begin
            st_en <= wdata[CTRL_EN];
            wren  <= wdata[CTRL_WREN];
         end
         if (hit_gain) begin
            gain0 <= wdata[GW-1:0];
            gain1 <= wdata[2*GW-1:GW];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           istat <= 1'b0;
      else if (fill_pulse)                  istat <= 1'b1;
      else if (hit_ist & wdata[IRQ_LOAD])   istat <= 1'b0;
   end
endmodule

// File: rtl/stcf_regfile.sv
module stcf_regfile
   import stcf_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DEPTH     = 128,
   parameter int          CW        = 16,
   parameter int          GW        = 16,
   parameter logic [31:0] REVISION  = 32'h0000_0010,
   parameter bit          MEM_RESET = 1'b1,
   localparam int         IDXW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [IDXW-1:0]   coef_raddr,
   output logic [CW-1:0]     coef_rdata,
   output logic [GW-1:0]     gain0,
   output logic [GW-1:0]     gain1,
   output logic              st_enable,
   output logic              clk_gate_req,
   output logic              irq
);
   generate
      if (ADDR_W < 6)            begin : g_bad_aw   $error("ADDR_W must cover offset 0x2C"); end
      if (DEPTH < 2 || (1 << IDXW) != DEPTH)
                                 begin : g_bad_dep  $error("DEPTH must be a power of two >= 2"); end
      if (CW > DATA_W)           begin : g_bad_cw   $error("CW exceeds bus width"); end
      if (2 * GW > DATA_W)       begin : g_bad_gw   $error("two gains must fit the bus word"); end
   endgenerate

   logic bus_wr, coef_wr;
   logic aidle, coef_wren, arm, istat, ien;
   logic load_done, fill_pulse;

   assign bus_wr  = bus_en & bus_we;
   assign coef_wr = bus_wr & (bus_addr == ADDR_W'(OFS_COEF));

   stcf_ctrl_regs #(.ADDR_W(ADDR_W), .GW(GW), .AIDLE_RST(1'b1)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .fill_pulse (fill_pulse),
      .aidle      (aidle),
      .st_en      (st_enable),
      .wren       (coef_wren),
      .arm        (arm),
      .istat      (istat),
      .ien        (ien),
      .gain0      (gain0),
      .gain1      (gain1)
   );

   stcf_coef_mem #(.DEPTH(DEPTH), .CW(CW), .MEM_RESET(MEM_RESET)) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_strobe  (coef_wr),
      .wr_data    (bus_wdata[CW-1:0]),
      .wren       (coef_wren),
      .arm        (arm),
      .rd_idx     (coef_raddr),
      .rd_data    (coef_rdata),
      .full       (load_done),
      .fill_pulse (fill_pulse)
   );

   assign clk_gate_req = aidle & ~st_enable;
   assign irq          = istat & ien;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_REV)) begin
         bus_rdata = REVISION;
      end else if (bus_addr == ADDR_W'(OFS_SYSCFG)) begin
         bus_rdata[SYS_AIDLE] = aidle;
      end else if (bus_addr == ADDR_W'(OFS_ISTAT)) begin
         bus_rdata[IRQ_LOAD] = istat;
      end else if (bus_addr == ADDR_W'(OFS_IEN)) begin
         bus_rdata[IRQ_LOAD] = ien;
      end else if (bus_addr == ADDR_W'(OFS_GAIN)) begin
         bus_rdata[2*GW-1:0] = {gain1, gain0};
      end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         bus_rdata[CTRL_EN]   = st_enable;
         bus_rdata[CTRL_WREN] = coef_wren;
         bus_rdata[CTRL_DONE] = load_done;
      end
   end
endmodule

// File: rtl/stcf_regfile_chk.sv
module stcf_regfile_chk
   import stcf_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          GW       = 16,
   parameter logic [31:0] REVISION = 32'h0000_0010
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [GW-1:0]     gain0,
   input logic [GW-1:0]     gain1,
   input logic              st_enable,
   input logic              clk_gate_req,
   input logic              irq,
   input logic              done_flag,
   input logic              wren_flag
);
   assert_rev_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_REV)) |-> (bus_rdata == REVISION));

   assert_gain_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == ADDR_W'(OFS_GAIN)) |=>
      (gain0 == $past(bus_wdata[GW-1:0]) && gain1 == $past(bus_wdata[2*GW-1:GW])));

   assert_done_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(bus_en && bus_we && wren_flag && bus_addr == ADDR_W'(OFS_COEF)));

   assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && bus_en && bus_we && bus_addr == ADDR_W'(OFS_COEF)) |=> done_flag);

   assert_rearm_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CTRL_WREN] && !wren_flag)
      |=> !done_flag);

   assert_gate_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_enable |-> !clk_gate_req);

   assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == ADDR_W'(OFS_ISTAT) && bus_wdata[IRQ_LOAD]) |=> !irq);
endmodule

bind stcf_regfile stcf_regfile_chk #(.ADDR_W(ADDR_W), .GW(GW), .REVISION(REVISION)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_en       (bus_en),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .gain0        (gain0),
   .gain1        (gain1),
   .st_enable    (st_enable),
   .clk_gate_req (clk_gate_req),
   .irq          (irq),
   .done_flag    (load_done),
   .wren_flag    (coef_wren)
);

// File: tb/stcf_regfile_tb.sv
module stcf_regfile_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 128;
   localparam logic [31:0] REV = 32'h0000_0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  coef_raddr = '0;
   logic [15:0] coef_rdata, gain0, gain1;
   logic        st_enable, clk_gate_req, irq;

   int n_cmp = 0, n_bad = 0;
   bit done_run = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   stcf_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .coef_raddr(coef_raddr),
      .coef_rdata(coef_rdata), .gain0(gain0), .gain1(gain1), .st_enable(st_enable),
      .clk_gate_req(clk_gate_req), .irq(irq)
   );

   // behavioural reference model
   logic [15:0] m_mem [DEPTH];
   int          m_cnt = 0;
   bit          m_aidle = 1, m_en = 0, m_wren = 0, m_st = 0, m_ie = 0;
   logic [31:0] m_gain = '0;

   initial for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
         m_cnt = 0; m_aidle = 1; m_en = 0; m_wren = 0; m_st = 0; m_ie = 0; m_gain = '0;
      end else if (bus_en && bus_we) begin
         case (bus_addr)
            8'h10: m_aidle = bus_wdata[0];
            8'h18: if (bus_wdata[0]) m_st = 0;
            8'h1C: m_ie = bus_wdata[0];
            8'h24: m_gain = bus_wdata;
            8'h28: if (m_wren && m_cnt < DEPTH) begin
                      m_mem[m_cnt] = bus_wdata[15:0];
                      m_cnt++;
                      if (m_cnt == DEPTH) m_st = 1;
                   end
            8'h2C: begin
                      if (bus_wdata[1] && !m_wren) m_cnt = 0;
                      m_en = bus_wdata[0];
                      m_wren = bus_wdata[1];
                   end
            default: ;
         endcase
      end
   end

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return REV;
         8'h10: return {31'b0, m_aidle};
         8'h18: return {31'b0, m_st};
         8'h1C: return {31'b0, m_ie};
         8'h24: return m_gain;
         8'h2C: return {29'b0, (m_cnt == DEPTH), m_wren, m_en};
         default: return '0;
      endcase
   endfunction

   function automatic logic [15:0] coefval(input int i);
      if (i == DEPTH - 1) return 16'h7FFF;
      return 16'((i * 499 + 32'h8000) & 32'hFFFF);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic compare();
      chk({cur_req, " rdata"},     bus_rdata, m_read(bus_addr));
      chk({cur_req, " st_enable"}, 32'(st_enable), 32'(m_en));
      chk({cur_req, " gate"},      32'(clk_gate_req), 32'(m_aidle && !m_en));
      chk({cur_req, " gain0"},     32'(gain0), 32'(m_gain[15:0]));
      chk({cur_req, " gain1"},     32'(gain1), 32'(m_gain[31:16]));
      chk({cur_req, " irq"},       32'(irq), 32'(m_st && m_ie));
      chk({cur_req, " coef"},      32'(coef_rdata), 32'(m_mem[coef_raddr]));
   endtask

   task automatic cyc(input logic en, input logic we, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      compare();
      bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, 1'b1, a, d);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      cyc(1'b0, 1'b0, a, '0);
      #1 chk(tag, bus_rdata, exp);
   endtask

   task automatic slot_chk(input string tag, input int idx, input logic [15:0] exp);
      cyc(1'b0, 1'b0, bus_addr, '0);
      coef_raddr = 7'(idx);
      #1 chk(tag, 32'(coef_rdata), 32'(exp));
   endtask

   task automatic sweep();
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1'b0, 1'b0, 8'h2C, '0);
         coef_raddr = 7'(i);
      end
   endtask

   task automatic finish_run();
      if (!done_run) begin
         done_run = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 syscfg", 8'h10, 32'h1);
      rd_chk("R1 ctrl",   8'h2C, 32'h0);
      rd_chk("R1 gain",   8'h24, 32'h0);
      rd_chk("R1 istat",  8'h18, 32'h0);
      chk("R1 gate", 32'(clk_gate_req), 32'h1);
      chk("R1 irq",  32'(irq), 32'h0);
      slot_chk("R1 slot5", 5, 16'h0);

      // R2 revision and unmapped
      cur_req = "R2";
      wr(8'h00, 32'hFFFF_FFFF);
      rd_chk("R2 rev", 8'h00, REV);
      rd_chk("R2 unmapped 0x04", 8'h04, 32'h0);
      rd_chk("R2 unaligned 0x11", 8'h11, 32'h0);
      rd_chk("R2 unmapped 0x30", 8'h30, 32'h0);
      rd_chk("R2 data port", 8'h28, 32'h0);

      // R3 gains
      cur_req = "R3";
      wr(8'h24, 32'h8000_7FFF);
      cyc(1'b0, 1'b0, 8'h24, '0);
      #1 chk("R3 gain0", 32'(gain0), 32'h7FFF);
      chk("R3 gain1", 32'(gain1), 32'h8000);
      wr(8'h24, 32'h1234_FEDC);
      rd_chk("R3 readback", 8'h24, 32'h1234_FEDC);

      // R8 enable and clock gate
      cur_req = "R8";
      wr(8'h2C, 32'h1);
      cyc(1'b0, 1'b0, 8'h2C, '0);
      #1 chk("R8 enable gate", 32'(clk_gate_req), 32'h0);
      chk("R8 st_enable", 32'(st_enable), 32'h1);
      wr(8'h2C, 32'h0);
      cyc(1'b0, 1'b0, 8'h2C, '0);
      #1 chk("R8 idle gate", 32'(clk_gate_req), 32'h1);
      wr(8'h10, 32'h0);
      cyc(1'b0, 1'b0, 8'h10, '0);
      #1 chk("R8 no autoidle", 32'(clk_gate_req), 32'h0);
      wr(8'h10, 32'h1);

      // R6 write with enable clear is ignored
      cur_req = "R6";
      wr(8'h28, 32'h0000_5555);
      slot_chk("R6 disabled write", 0, 16'h0);

      // R4 / R5 full load
      cur_req = "R4";
      wr(8'h2C, 32'h2);
      for (int i = 0; i < DEPTH - 1; i++) wr(8'h28, {16'hABCD, coefval(i)});
      cur_req = "R5";
      rd_chk("R5 not done at 127", 8'h2C, 32'h2);
      wr(8'h28, {16'h0, coefval(DEPTH - 1)});
      rd_chk("R5 done at 128", 8'h2C, 32'h6);
      cur_req = "R4";
      slot_chk("R4 slot0 min", 0, 16'h8000);
      slot_chk("R4 slot64", 64, coefval(64));
      slot_chk("R4 slot127 max", 127, 16'h7FFF);

      // R6 overrun ignored
      cur_req = "R6";
      wr(8'h28, 32'h0000_1234);
      rd_chk("R6 done held", 8'h2C, 32'h6);
      slot_chk("R6 slot0 unchanged", 0, 16'h8000);
      sweep();

      // R9 interrupt
      cur_req = "R9";
      rd_chk("R9 status set", 8'h18, 32'h1);
      chk("R9 masked", 32'(irq), 32'h0);
      wr(8'h1C, 32'h1);
      cyc(1'b0, 1'b0, 8'h1C, '0);
      #1 chk("R9 irq on", 32'(irq), 32'h1);
      wr(8'h18, 32'h0);
      cyc(1'b0, 1'b0, 8'h18, '0);
      #1 chk("R9 write0 keeps", 32'(irq), 32'h1);
      wr(8'h18, 32'h1);
      cyc(1'b0, 1'b0, 8'h18, '0);
      #1 chk("R9 w1c", 32'(irq), 32'h0);

      // R7 re-arm
      cur_req = "R7";
      wr(8'h2C, 32'h0);
      rd_chk("R7 done kept on clear", 8'h2C, 32'h4);
      wr(8'h2C, 32'h3);
      rd_chk("R7 rearm clears done", 8'h2C, 32'h3);
      wr(8'h28, 32'h1111);
      wr(8'h28, 32'h2222);
      wr(8'h28, 32'h3333);
      slot_chk("R7 slot0 restart", 0, 16'h1111);
      slot_chk("R7 slot2", 2, 16'h3333);
      slot_chk("R7 slot3 old", 3, coefval(3));
      sweep();
      cyc(1'b0, 1'b0, 8'h00, '0);
      cyc(1'b0, 1'b0, 8'h00, '0);
      finish_run();
   end
endmodule